// File: doc/BRIEF.md
# Strap-Configured Audio Clock Master

This block produces the serial bit clock and the frame (left/right) clock for a stereo audio converter that runs as the clock master. Both clocks are derived from the master clock input (`mclk`). The two clock pins are shared. After reset they act as configuration inputs for a fixed window of master-clock cycles. At the end of that window the block latches four levels:

- the level of the serial-data pin, which selects the master or slave role;
- the level of the frame-clock pin, which selects single or double speed;
- the level of the bit-clock pin, which selects the divide family (binary or ×3);
- a ratio-select input, which selects the lower or higher ratio inside the family.

In the master role, the block then enables its pin drivers and starts both clocks. In the slave role it leaves the pins undriven.

The bit clock always runs at 64 times the frame rate. Each frame clock edge falls on a bit clock falling edge. The block also gives a one-cycle strobe on each bit clock falling edge, so that a serializer in the master-clock domain can shift out its next bit.

Top module: `audio_clk_master`

## Requirements
- R1: While `rstN` is low, and during the strap window after its release, `clkOe`, `bitClkOut`, `lrClkOut` and `bitFallStb` are all 0.
- R2: The strap window lasts WIN master-clock rising edges after reset release, with WIN a parameter (default 1024). On the WIN-th edge all four strap levels are captured. If `strapData` was 1 there, `clkOe` is 1 from that edge on.
- R3: If `strapData` was 0 at capture (slave role), `clkOe`, both clocks and the strobe stay 0 until the next reset.
- R4: The bit-clock period in master-clock cycles is D = B << S. B is 2 when `padBitIn` was 0 and 3 when it was 1. S is (1 when `padLrIn` was 0, single speed, else 0) plus (1 when `ratioSel` was 1). This gives the MCLK/frame ratios 256, 512, 384 and 768 in single speed, and 128, 256, 192 and 384 in double speed.
- R5: Starting with the capture edge, each bit-clock period is low for ceil(D/2) cycles, then high for floor(D/2) cycles.
- R6: The frame clock starts low. It toggles after every 32 bit-clock periods, so its period is 64·D cycles. It changes only in a cycle in which the bit clock falls.
- R7: `bitFallStb` is 1 for exactly the cycle in which `bitClkOut` first reads 0 after being 1, and is 0 otherwise.
- R8: Changes on `strapData`, `padLrIn`, `padBitIn` or `ratioSel` after capture have no effect on the clocks or on `clkOe`.
- R9: Asserting `rstN` low during operation clears `clkOe` at once, without waiting for a clock edge. After release, the strap window runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapData | input | 1 | Level seen on the serial-data pin (1 = master) |
| padLrIn | input | 1 | Level seen on the frame-clock pin (1 = double speed) |
| padBitIn | input | 1 | Level seen on the bit-clock pin (1 = ×3 family) |
| ratioSel | input | 1 | 1 selects the higher ratio of the family |
| clkOe | output | 1 | Drive enable for both clock pins |
| bitClkOut | output | 1 | Bit clock |
| lrClkOut | output | 1 | Frame clock |
| bitFallStb | output | 1 | One-cycle strobe at each bit-clock falling edge |

## Verification
`clkOe` rises on the WIN-th rising edge after reset release. The bench samples it on the falling edge just before that point, where it must still be 0, and just after, where it must be 1. The cycle right after the capture edge is taken as phase 0. From there, each later falling-edge sample k has an exact expected value:
- bit clock: (k mod D) ≥ ceil(D/2);
- strobe: k mod D = 0 with k > 0;
- frame clock: bit 5 of k/D.

These expected values are checked for more than a full frame in every configuration. Reset is checked a few nanoseconds after `rstN` falls, with no edge in between.

// File: rtl/audio_clk_master_pkg.sv
package audio_clk_master_pkg;
  localparam int DIV_W = 4;         // holds the largest divisor, 12
  localparam int FRAME_BITS = 64;   // bit clocks per frame
  localparam int BIT_W = $clog2(FRAME_BITS);

  typedef struct packed {
    logic master;   // role strap
    logic dbl;      // double speed
    logic triFam;   // x3 divide family
    logic hiSel;    // higher ratio inside the family
  } strapCfg_t;

  typedef struct packed {
    logic run;      // clocks enabled
  } ctrlStb_t;

  function automatic logic [DIV_W-1:0] calcDiv(input strapCfg_t c);
    logic [DIV_W-1:0] base;
    logic [DIV_W-1:0] shamt;
    base  = c.triFam ? DIV_W'(3) : DIV_W'(2);
    shamt = DIV_W'(!c.dbl) + DIV_W'(c.hiSel);
    return base << shamt;
  endfunction
endpackage

// File: rtl/audio_clk_master_ctrl.sv
module audio_clk_master_ctrl
  import audio_clk_master_pkg::*;
#(
  parameter int WIN = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapData,
  input  logic             padLrIn,
  input  logic             padBitIn,
  input  logic             ratioSel,
  output ctrlStb_t         stb,
  output logic [DIV_W-1:0] divisor,
  output logic             clkOe
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0] winCnt;
  logic             active;
  strapCfg_t        cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      active <= 1'b0;
      cfgQ   <= '0;
    end else if (!active) begin
      if (winCnt == WIN_W'(WIN - 1)) begin
        active      <= 1'b1;
        cfgQ.master <= strapData;
        cfgQ.dbl    <= padLrIn;
        cfgQ.triFam <= padBitIn;
        cfgQ.hiSel  <= ratioSel;
      end else begin
        winCnt <= winCnt + 1'b1;
      end
    end
  end

  assign stb.run = active & cfgQ.master;
  assign clkOe   = stb.run;
  assign divisor = calcDiv(cfgQ);
endmodule

// File: rtl/audio_clk_master_dp.sv
module audio_clk_master_dp
  import audio_clk_master_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [DIV_W-1:0] divisor,
  output logic             bitClk,
  output logic             lrClk,
  output logic             fallStb
);
  logic [DIV_W-1:0] ph, phNext, lowLen;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic             wrap;

  always_comb begin
    lowLen  = (divisor + 1'b1) >> 1;
    wrap    = stb.run && (ph == divisor - 1'b1);
    phNext  = wrap ? '0 : ph + 1'b1;
    bitNext = wrap ? bitCnt + 1'b1 : bitCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph      <= '0;
      bitCnt  <= '0;
      bitClk  <= 1'b0;
      lrClk   <= 1'b0;
      fallStb <= 1'b0;
    end else if (!stb.run) begin
      ph      <= '0;
      bitCnt  <= '0;
      bitClk  <= 1'b0;
      lrClk   <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      ph      <= phNext;
      bitCnt  <= bitNext;
      bitClk  <= (phNext >= lowLen);
      lrClk   <= bitNext[BIT_W-1];
      fallStb <= wrap;
    end
  end
endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
  import audio_clk_master_pkg::*;
#(
  parameter int WIN = 1024
) (
  input  logic mclk,
  input  logic rstN,
  input  logic strapData,
  input  logic padLrIn,
  input  logic padBitIn,
  input  logic ratioSel,
  output logic clkOe,
  output logic bitClkOut,
  output logic lrClkOut,
  output logic bitFallStb
);
  ctrlStb_t         stb;
  logic [DIV_W-1:0] divisor;

  audio_clk_master_ctrl #(.WIN(WIN)) ctrl_i (
    .clk(mclk), .rstN(rstN), .strapData(strapData), .padLrIn(padLrIn),
    .padBitIn(padBitIn), .ratioSel(ratioSel), .stb(stb),
    .divisor(divisor), .clkOe(clkOe)
  );

  audio_clk_master_dp dp_i (
    .clk(mclk), .rstN(rstN), .stb(stb), .divisor(divisor),
    .bitClk(bitClkOut), .lrClk(lrClkOut), .fallStb(bitFallStb)
  );
endmodule

// File: rtl/audio_clk_master_chk.sv
module audio_clk_master_chk (
  input logic clk,
  input logic rstN,
  input logic clkOe,
  input logic bitClk,
  input logic lrClk,
  input logic fallStb
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !clkOe |-> (!bitClk && !lrClk && !fallStb));
  a_r2_oe_sticky: assert property (@(posedge clk) disable iff (!rstN)
    clkOe |=> clkOe);
  a_r6_lr_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrClk) |-> fallStb);
  a_r7_strobe_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> (!bitClk && $past(bitClk)));
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |=> !fallStb);
endmodule

bind audio_clk_master audio_clk_master_chk chk_i (
  .clk(mclk), .rstN(rstN), .clkOe(clkOe), .bitClk(bitClkOut),
  .lrClk(lrClkOut), .fallStb(bitFallStb)
);

// File: tb/audio_clk_master_tb.sv
module audio_clk_master_tb_top;
  localparam int WIN = 64;

  logic mclk = 1'b0;
  logic rstN = 1'b0;
  logic strapData = 1'b0, padLrIn = 1'b0, padBitIn = 1'b0, ratioSel = 1'b0;
  logic clkOe, bitClkOut, lrClkOut, bitFallStb;
  int   nChecks = 0;
  int   nFails = 0;

  always #5 mclk = ~mclk;

  audio_clk_master #(.WIN(WIN)) dut_i (
    .mclk(mclk), .rstN(rstN), .strapData(strapData), .padLrIn(padLrIn),
    .padBitIn(padBitIn), .ratioSel(ratioSel), .clkOe(clkOe),
    .bitClkOut(bitClkOut), .lrClkOut(lrClkOut), .bitFallStb(bitFallStb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reset with the given pin levels; returns at the sample just after capture.
  task automatic resetAndWait(input bit st, input bit lr, input bit bc, input bit hi);
    @(negedge mclk);
    rstN = 1'b0;
    strapData = st; padLrIn = lr; padBitIn = bc; ratioSel = hi;
    repeat (3) @(negedge mclk);
    chk({clkOe, bitClkOut, lrClkOut, bitFallStb} == 4'b0, "R1 in reset",
        {clkOe, bitClkOut, lrClkOut, bitFallStb}, 0);
    rstN = 1'b1;
    for (int i = 1; i <= WIN; i++) begin
      @(negedge mclk);
      if (i == 1 || i == WIN - 1)
        chk({clkOe, bitClkOut, lrClkOut, bitFallStb} == 4'b0, "R1 window",
            {clkOe, bitClkOut, lrClkOut, bitFallStb}, 0);
    end
  endtask

  // Master run in one configuration; flip = change pins after capture (R8).
  task automatic runMaster(input bit lr, input bit bc, input bit hi, input bit flip);
    int d, low;
    d   = (bc ? 3 : 2) << ((lr ? 0 : 1) + (hi ? 1 : 0));
    low = (d + 1) / 2;
    resetAndWait(1'b1, lr, bc, hi);
    chk(clkOe == 1'b1, "R2 oe at capture", clkOe, 1);
    if (flip) begin
      strapData = 1'b0; padLrIn = ~lr; padBitIn = ~bc; ratioSel = ~hi;
    end
    for (int k = 0; k < 64 * d + d + 1; k++) begin
      if (k > 0) @(negedge mclk);
      chk(bitClkOut == ((k % d) >= low), flip ? "R8 bit clock" : "R4 R5 bit clock",
          bitClkOut, int'((k % d) >= low));
      chk(lrClkOut == (((k / d) % 64) >= 32), "R6 frame clock",
          lrClkOut, int'(((k / d) % 64) >= 32));
      chk(bitFallStb == ((k % d) == 0 && k > 0), "R7 strobe",
          bitFallStb, int'((k % d) == 0 && k > 0));
      if (flip) chk(clkOe == 1'b1, "R8 oe held", clkOe, 1);
    end
  endtask

  task automatic runSlave();
    resetAndWait(1'b0, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 300; k++) begin
      @(negedge mclk);
      chk({clkOe, bitClkOut, lrClkOut, bitFallStb} == 4'b0, "R3 slave quiet",
          {clkOe, bitClkOut, lrClkOut, bitFallStb}, 0);
    end
  endtask

  task automatic midReset();
    resetAndWait(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (37) @(negedge mclk);
    chk(clkOe == 1'b1, "R9 running", clkOe, 1);
    #2 rstN = 1'b0;
    #1 chk(clkOe == 1'b0, "R9 async clear", clkOe, 0);
    runMaster(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge mclk);
    runMaster(1'b0, 1'b0, 1'b0, 1'b0); // 256x, D=4
    runMaster(1'b0, 1'b0, 1'b1, 1'b0); // 512x, D=8
    runMaster(1'b0, 1'b1, 1'b0, 1'b0); // 384x, D=6
    runMaster(1'b0, 1'b1, 1'b1, 1'b0); // 768x, D=12
    runMaster(1'b1, 1'b0, 1'b0, 1'b0); // 128x, D=2
    runMaster(1'b1, 1'b0, 1'b1, 1'b0); // 256x, D=4
    runMaster(1'b1, 1'b1, 1'b0, 1'b0); // 192x, D=3
    runMaster(1'b1, 1'b1, 1'b1, 1'b0); // 384x, D=6
    runMaster(1'b1, 1'b1, 1'b0, 1'b1); // R8 with pins flipped
    runSlave();
    midReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule